// File: doc/BRIEF.md
# Serial Receiver with Receive Queue and Idle Timeout Flag

This block takes an asynchronous serial line, recovers 8-bit characters from it with a 16x oversampling tick, and stores them in a 64-entry receive queue. Software or a DMA engine pops characters from the queue through one read port. A count output gives the current queue occupancy. A full-level output rises once the occupancy reaches a programmable trigger level.

When a short burst leaves the queue below the trigger level, the full-level output never rises. For that case the block raises a data-ready flag once the line has been silent for 15 bit-times after the last stored character. Software clears the flag with a handshake: it reads the flag while it is 1, drains the queue, then writes 0. If a DMA engine drains the queue, the flag clears by itself. A line break is recognised and kept out of the queue.

Top module: `uart_rx_idle`

## Requirements
- R1: The queue holds up to DEPTH (64) characters and returns them in arrival order on `rdData`, which shows the oldest entry before the pop. `fifoCount` always equals the number stored.
- R2: A frame is a 0 start bit, 8 data bits least significant first, and one stop bit. Each bit is 16 ticks of `baudTick` and is sampled near its middle. A frame with a 1 stop bit is stored.
- R3: `dataReady` rises when both of these hold: 240 ticks have passed since the stop-bit sample of the last stored character with no new start bit, and at that moment `fifoCount` is nonzero and below `trigLevel`. A start bit restarts this silence window.
- R4: `dataReady` never rises while `syncMode` is 1. A silence window open when `syncMode` is asserted is abandoned.
- R5: Writing 1 (`flagWrEn` with `flagWrData`=1) does not change `dataReady`. Writing 0 clears it only if `flagRead` was pulsed while it was 1 and `fifoCount` is 0 at the write. Otherwise the write does nothing.
- R6: A `dmaRd` that pops the last stored character clears `dataReady`. Reset clears it too.
- R7: With `twoStop`=1, only the first stop bit must be 1. The level of the second stop bit does not affect storing.
- R8: A frame with all-zero data and a 0 stop bit is a break. It is not stored, and `lineBreak` stays 1 until the line returns to 1. Reception then resumes.
- R9: A frame with a 0 stop bit and nonzero data is discarded, and the receiver waits for the line to return to 1 before hunting.
- R10: A pop (`fifoRd` or `dmaRd`) on an empty queue leaves `fifoCount` unchanged.
- R11: `rxFull` is 1 exactly when `fifoCount` >= `trigLevel`.
- R12: A character arriving while the queue is full is dropped. `overrun` then goes to 1 and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| trigLevel | input | 7 | Receive trigger level, 1 to 64 |
| twoStop | input | 1 | 1 selects two stop bits |
| syncMode | input | 1 | 1 suppresses the idle timeout flag |
| flagRead | input | 1 | Pulse: software reads the flag register |
| flagWrEn | input | 1 | Pulse: software writes the flag register |
| flagWrData | input | 1 | Value written to the flag |
| fifoRd | input | 1 | Processor pop of one character |
| dmaRd | input | 1 | DMA pop of one character |
| rdData | output | 8 | Oldest stored character |
| fifoCount | output | 7 | Number of stored characters |
| rxFull | output | 1 | Occupancy at or above trigger level |
| dataReady | output | 1 | Idle timeout flag |
| lineBreak | output | 1 | Break in progress |
| overrun | output | 1 | Sticky overflow indication |

## Verification
The bench uses the default parameters: 64 entries, 16 ticks per bit, a 15-bit-time timeout and a two-flop synchroniser. It drives one tick every second clock, so a full-queue overflow of 66 back-to-back frames fits the run. At this tick rate the 240-tick silence window can be probed on both sides, about 30 ticks before and after expiry. The trigger level is moved between 3, 4, 8 and 64 to reach both sides of the full-level compare and the case where the flag is held off by occupancy.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       push;
    logic [7:0] data;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_STOP2, ST_MARK
  } rxState_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS          = 16,
  parameter int TIMEOUT_BITS = 15,
  parameter int DEPTH        = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxLine,
  input  logic                       baudTick,
  input  logic                       twoStop,
  input  logic                       syncMode,
  input  logic [$clog2(DEPTH):0]     trigLevel,
  input  logic [$clog2(DEPTH):0]     fifoCount,
  input  logic                       flagRead,
  input  logic                       flagWrEn,
  input  logic                       flagWrData,
  input  logic                       dmaRd,
  output rxStrobe_t                  strobe,
  output logic                       dataReady,
  output logic                       lineBreak
);
  localparam int TW       = $clog2(OVS);
  localparam int HALF     = OVS / 2;
  localparam int TO_TICKS = OVS * TIMEOUT_BITS;
  localparam int TCW      = $clog2(TO_TICKS + 1);
  localparam int CW       = $clog2(DEPTH) + 1;

  // input synchroniser chain, one flop per stage
  logic [SYNC_STAGES-1:0] syncQ;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) syncQ[g] <= 1'b1;
          else        syncQ[g] <= rxLine;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) syncQ[g] <= 1'b1;
          else        syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate
  logic rxS;
  assign rxS = syncQ[SYNC_STAGES-1];

  rxState_t   state;
  logic [TW-1:0] tickCnt;
  logic [2:0]    bitIdx;
  logic [7:0]    shiftReg;
  logic          startDet;

  assign startDet = (state == ST_IDLE) && baudTick && !rxS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tickCnt     <= '0;
      bitIdx      <= '0;
      shiftReg    <= '0;
      strobe      <= '0;
      lineBreak   <= 1'b0;
    end else begin
      strobe.push <= 1'b0;
      if (baudTick) begin
        unique case (state)
          ST_IDLE: begin
            if (!rxS) begin
              state   <= ST_START;
              tickCnt <= '0;
            end
          end
          ST_START: begin
            if (tickCnt == TW'(HALF - 1)) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= rxS ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (tickCnt == TW'(OVS - 1)) begin
              tickCnt  <= '0;
              shiftReg <= {rxS, shiftReg[7:1]};
              if (bitIdx == 3'd7) state <= ST_STOP;
              bitIdx   <= bitIdx + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (tickCnt == TW'(OVS - 1)) begin
              tickCnt <= '0;
              if (rxS) begin
                strobe.push <= 1'b1;
                strobe.data <= shiftReg;
                state       <= twoStop ? ST_STOP2 : ST_IDLE;
              end else begin
                lineBreak <= (shiftReg == 8'h00);
                state     <= ST_MARK;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_STOP2: begin
            // second stop bit is timed but its level is not examined
            if (tickCnt == TW'(OVS - 1)) begin
              tickCnt <= '0;
              state   <= ST_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_MARK: begin
            if (rxS) begin
              lineBreak <= 1'b0;
              state     <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // idle silence timer
  logic           timerOn;
  logic [TCW-1:0] timerCnt;
  logic           expire;

  assign expire = timerOn && baudTick && !syncMode && !strobe.push && !startDet
                  && (timerCnt == TCW'(TO_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerOn  <= 1'b0;
      timerCnt <= '0;
    end else if (syncMode) begin
      timerOn <= 1'b0;
    end else if (strobe.push) begin
      timerOn  <= 1'b1;
      timerCnt <= '0;
    end else if (startDet) begin
      timerOn <= 1'b0;
    end else if (timerOn && baudTick) begin
      if (expire) timerOn  <= 1'b0;
      else        timerCnt <= timerCnt + 1'b1;
    end
  end

  // flag and its clear handshake
  logic readArmed;
  logic clrSw, clrDma, setFlag;

  assign clrSw   = flagWrEn && !flagWrData && readArmed && (fifoCount == '0);
  assign clrDma  = dmaRd && (fifoCount == CW'(1));
  assign setFlag = expire && (fifoCount != '0) && (fifoCount < trigLevel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataReady <= 1'b0;
      readArmed <= 1'b0;
    end else if (clrSw || clrDma) begin
      dataReady <= 1'b0;
      readArmed <= 1'b0;
    end else begin
      if (setFlag) dataReady <= 1'b1;
      if (flagRead && dataReady) readArmed <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rxStrobe_t              strobe,
  input  logic                   fifoRd,
  input  logic                   dmaRd,
  input  logic [$clog2(DEPTH):0] trigLevel,
  output logic [7:0]             rdData,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic                   rxFull,
  output logic                   overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          full, empty, doPush, doPop;

  assign full   = (fifoCount == CW'(DEPTH));
  assign empty  = (fifoCount == '0);
  assign doPush = strobe.push && !full;
  assign doPop  = (fifoRd || dmaRd) && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= strobe.data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      overrun   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop)      fifoCount <= fifoCount + 1'b1;
      else if (doPop && !doPush) fifoCount <= fifoCount - 1'b1;
      if (strobe.push && full) overrun <= 1'b1;
    end
  end

  assign rdData = mem[rdPtr];
  assign rxFull = (fifoCount >= trigLevel);
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle
  import uart_rx_pkg::*;
#(
  parameter int OVS          = 16,
  parameter int TIMEOUT_BITS = 15,
  parameter int DEPTH        = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rxLine,
  input  logic                   baudTick,
  input  logic [$clog2(DEPTH):0] trigLevel,
  input  logic                   twoStop,
  input  logic                   syncMode,
  input  logic                   flagRead,
  input  logic                   flagWrEn,
  input  logic                   flagWrData,
  input  logic                   fifoRd,
  input  logic                   dmaRd,
  output logic [7:0]             rdData,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic                   rxFull,
  output logic                   dataReady,
  output logic                   lineBreak,
  output logic                   overrun
);
  rxStrobe_t strobe;

  uart_rx_ctrl #(
    .OVS(OVS), .TIMEOUT_BITS(TIMEOUT_BITS), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .baudTick(baudTick),
    .twoStop(twoStop), .syncMode(syncMode), .trigLevel(trigLevel),
    .fifoCount(fifoCount), .flagRead(flagRead), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .dmaRd(dmaRd), .strobe(strobe),
    .dataReady(dataReady), .lineBreak(lineBreak)
  );

  uart_rx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fifoRd(fifoRd), .dmaRd(dmaRd),
    .trigLevel(trigLevel), .rdData(rdData), .fifoCount(fifoCount),
    .rxFull(rxFull), .overrun(overrun)
  );
endmodule

// File: rtl/uart_rx_idle_chk.sv
module uart_rx_idle_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [$clog2(DEPTH):0] trigLevel,
  input logic                   syncMode,
  input logic                   flagWrEn,
  input logic                   flagWrData,
  input logic                   fifoRd,
  input logic                   dmaRd,
  input logic [$clog2(DEPTH):0] fifoCount,
  input logic                   dataReady,
  input logic                   overrun
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= CW'(DEPTH));

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoCount == $past(fifoCount)) || (fifoCount == $past(fifoCount) + 1'b1)
    || (fifoCount + 1'b1 == $past(fifoCount)));

  p_rise_below_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataReady) |-> ($past(fifoCount) < $past(trigLevel)) && ($past(fifoCount) != '0));

  p_sync_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataReady) |-> !$past(syncMode));

  p_write_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flagWrEn && flagWrData && dataReady && !dmaRd |=> dataReady);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoRd || dmaRd) && fifoCount == '0 |=> fifoCount <= CW'(1));

  p_full_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount == CW'(DEPTH) && !fifoRd && !dmaRd |=> fifoCount == CW'(DEPTH));

  p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind uart_rx_idle uart_rx_idle_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trigLevel(trigLevel), .syncMode(syncMode),
  .flagWrEn(flagWrEn), .flagWrData(flagWrData), .fifoRd(fifoRd), .dmaRd(dmaRd),
  .fifoCount(fifoCount), .dataReady(dataReady), .overrun(overrun)
);

// File: tb/sim_uart_rx_idle.sv
module sim_uart_rx_idle;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxLine = 1'b1;
  logic baudTick = 1'b0;
  logic [6:0] trigLevel = 7'd8;
  logic twoStop = 1'b0, syncMode = 1'b0;
  logic flagRead = 1'b0, flagWrEn = 1'b0, flagWrData = 1'b0;
  logic fifoRd = 1'b0, dmaRd = 1'b0;
  logic [7:0] rdData;
  logic [6:0] fifoCount;
  logic rxFull, dataReady, lineBreak, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  byte unsigned model[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) baudTick <= 1'b0;
    else        baudTick <= ~baudTick;
  end

  uart_rx_idle u0 (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .baudTick(baudTick),
    .trigLevel(trigLevel), .twoStop(twoStop), .syncMode(syncMode),
    .flagRead(flagRead), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .fifoRd(fifoRd), .dmaRd(dmaRd), .rdData(rdData), .fifoCount(fifoCount),
    .rxFull(rxFull), .dataReady(dataReady), .lineBreak(lineBreak), .overrun(overrun)
  );

  function automatic int expFull(int cnt, int trig);
    return (cnt >= trig) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTicks(int n);
    repeat (2 * n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    @(negedge clk);
    rxLine = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic sendFrame(byte unsigned d, logic s1, logic s2, bit two);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(s1);
    if (two) sendBit(s2);
    rxLine = 1'b1;
  endtask

  task automatic pulseFlagRead();
    @(negedge clk); flagRead = 1'b1;
    @(negedge clk); flagRead = 1'b0;
  endtask

  task automatic writeFlag(logic v);
    @(negedge clk); flagWrEn = 1'b1; flagWrData = v;
    @(negedge clk); flagWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic popCheck(string req, bit useDma);
    byte unsigned e;
    @(negedge clk);
    e = model.pop_front();
    check(req, rdData, e);
    if (useDma) dmaRd = 1'b1; else fifoRd = 1'b1;
    @(negedge clk);
    dmaRd = 1'b0; fifoRd = 1'b0;
  endtask

  task automatic sendRandom(int n);
    for (int i = 0; i < n; i++) begin
      byte unsigned d = byte'($urandom_range(1, 255));
      sendFrame(d, 1'b1, 1'b1, twoStop);
      if (model.size() < 64) model.push_back(d);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R1 reset count", fifoCount, 0);
    check("R6 reset flag", dataReady, 0);
    check("R11 reset full", rxFull, expFull(0, 8));
    check("R12 reset overrun", overrun, 0);

    // R2/R3: short burst then silence
    sendRandom(3);
    check("R2 count after burst", fifoCount, 3);
    waitTicks(200);
    check("R3 flag before timeout", dataReady, 0);
    waitTicks(60);
    check("R3 flag after timeout", dataReady, 1);

    // R11 compare around trigger level
    trigLevel = 7'd3; @(negedge clk);
    check("R11 full at trig", rxFull, expFull(3, 3));
    trigLevel = 7'd4; @(negedge clk);
    check("R11 below trig", rxFull, expFull(3, 4));
    trigLevel = 7'd8;

    // R5 clear handshake
    writeFlag(1'b0);
    check("R5 write0 without read", dataReady, 1);
    pulseFlagRead();
    writeFlag(1'b0);
    check("R5 write0 with data left", dataReady, 1);
    for (int i = 0; i < 3; i++) popCheck("R1 R2 order", 1'b0);
    writeFlag(1'b1);
    check("R5 write1 no effect", dataReady, 1);
    writeFlag(1'b0);
    check("R5 write0 after drain", dataReady, 0);

    // R10 empty pop
    @(negedge clk); fifoRd = 1'b1; @(negedge clk); fifoRd = 1'b0;
    @(negedge clk); dmaRd = 1'b1; @(negedge clk); dmaRd = 1'b0;
    @(negedge clk);
    check("R10 empty pop count", fifoCount, 0);

    // R4 synchronous mode suppresses flag
    syncMode = 1'b1;
    sendRandom(2);
    waitTicks(300);
    check("R4 no flag in sync mode", dataReady, 0);
    syncMode = 1'b0;
    waitTicks(300);
    check("R4 window abandoned", dataReady, 0);
    for (int i = 0; i < 2; i++) popCheck("R1 sync drain", 1'b1);

    // R6 DMA drain clears flag
    sendRandom(2);
    waitTicks(270);
    check("R6 flag set", dataReady, 1);
    popCheck("R6 data", 1'b1);
    check("R6 flag kept with data", dataReady, 1);
    popCheck("R6 data", 1'b1);
    check("R6 flag cleared by dma", dataReady, 0);

    // R3 start bit restarts window
    sendRandom(1);
    waitTicks(150);
    sendRandom(1);
    check("R3 restart not expired", dataReady, 0);
    waitTicks(150);
    check("R3 restart early", dataReady, 0);
    waitTicks(120);
    check("R3 restart expired", dataReady, 1);
    for (int i = 0; i < 2; i++) popCheck("R6 drain", 1'b1);
    check("R6 cleared", dataReady, 0);

    // R7 two stop bits, second unchecked
    twoStop = 1'b1;
    sendFrame(8'hA5, 1'b1, 1'b0, 1'b1);
    model.push_back(8'hA5);
    waitTicks(4);
    check("R7 stored with low second stop", fifoCount, 1);
    // R9 framing error discarded
    sendFrame(8'h3C, 1'b0, 1'b1, 1'b1);
    waitTicks(4);
    check("R9 bad stop dropped", fifoCount, 1);
    check("R9 not a break", lineBreak, 0);
    twoStop = 1'b0;
    sendFrame(8'h5A, 1'b1, 1'b1, 1'b0);
    model.push_back(8'h5A);
    check("R9 resumes", fifoCount, 2);
    popCheck("R7 data", 1'b1);
    popCheck("R9 data", 1'b1);

    // R8 break
    sendBit(1'b0);
    for (int i = 0; i < 9; i++) sendBit(1'b0);
    waitTicks(40);
    check("R8 break flagged", lineBreak, 1);
    check("R8 break not stored", fifoCount, 0);
    rxLine = 1'b1;
    waitTicks(20);
    check("R8 break ended", lineBreak, 0);
    sendFrame(8'h00, 1'b1, 1'b1, 1'b0);
    model.push_back(8'h00);
    check("R8 zero byte stored after break", fifoCount, 1);
    popCheck("R8 data", 1'b1);

    // R12 overflow
    trigLevel = 7'd64;
    sendRandom(66);
    check("R12 full count", fifoCount, 64);
    check("R12 overrun", overrun, 1);
    check("R11 full at 64", rxFull, expFull(64, 64));
    waitTicks(260);
    check("R3 no flag at trig", dataReady, 0);
    for (int i = 0; i < 64; i++) popCheck("R12 kept order", 1'b0);
    check("R12 drained", fifoCount, 0);
    check("R12 sticky", overrun, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule